// File: doc/BRIEF.md
# Configurable ROM Window Chip-Select Decoder

This block produces the three active-low chip selects of a 64 KB, 8-bit CPU memory space: a fixed RAM in the lower half, a second RAM in the upper half, and a ROM window at the very top. Only the upper address byte (A15..A8) is decoded, so the finest resolution is one 256-byte page. The decode is gated by an active-low memory-request strobe. When the strobe is inactive, as on an I/O cycle, none of the memories is selected.

The ROM window is 8 KB by default ($E000-$FFFF). A five-bit static configuration mask can add the lines A12 down to A8, one at a time, to the ROM compare. Each line added halves the window from the top, so the smallest window is the single page $FF00-$FFFF. The upper RAM takes every upper-half address that the ROM does not claim. The mask only has meaning as a run of set bits starting at A12. Any set bit below the first clear bit is ignored, which keeps the window one aligned block.

The decode is combinational. A single output register stage sits after it, so every result appears exactly one clock after its inputs are sampled.

Top module: `rom_window_decoder`

## Requirements
- R1: While reset is asserted, and until the first input has been sampled after reset, all three selects are high.
- R2: Every select reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: The lower RAM select is low exactly when the request strobe is low and A15 is 0.
- R4: When the request strobe is high, all three selects are high, whatever the address and mask.
- R5: Mask bit k (k = 0..4) enables the compare of address line A(8+k). With the mask all zero, only A15..A13 are compared and the ROM occupies $E000-$FFFF.
- R6: The ROM select is low exactly when the request strobe is low, A15..A13 are all 1, and every effectively enabled line is 1. The ROM base equals $10000 minus (8 KB shifted right by the number of effective mask bits).
- R7: The effective mask is the run of set bits from bit 4 (A12) downward, ending at the first clear bit. Set bits below that first clear bit have no effect.
- R8: The upper RAM select is low exactly when the request strobe is low, A15 is 1, and the ROM compare is false.
- R9: At most one select is low in any cycle.
- R10: With the mask at 11111, the ROM is the single page $FF00-$FFFF and the upper RAM covers $8000-$FEFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_hi | input | 8 | Address lines A15..A8 (bit 7 = A15) |
| mreq_n | input | 1 | Active-low memory-request strobe |
| cfg_mask | input | 5 | Compare enables for A12..A8 (bit k = A(8+k)) |
| lo_ram_cs_n | output | 1 | Lower RAM select, active low |
| hi_ram_cs_n | output | 1 | Upper RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |

## Verification
Each of the three selects is due exactly one clock after its address, strobe and mask are applied, because a single register stage follows the decode. The driver applies one stimulus per falling edge and queues the expected select triple, which it computes from the ROM base address. The monitor removes one entry from the queue just after each rising edge and compares it with the registered outputs. This lines every result up with the cycle that caused it. The stimulus covers all 256 upper-address values under all 32 mask settings, with the strobe both active and inactive.

// File: rtl/rom_window_decoder.sv
module rom_window_decoder #(
  parameter int HI_W  = 8,
  parameter int FIX_W = 3,
  localparam int MASK_W = HI_W - FIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic              mreq_n,
  input  logic [MASK_W-1:0] cfg_mask,
  output logic              lo_ram_cs_n,
  output logic              hi_ram_cs_n,
  output logic              rom_cs_n
);

  logic [MASK_W-1:0] eff_mask;
  logic              fixed_hit, rom_hit;
  logic              lo_sel, hi_sel, rom_sel;

  assign eff_mask[MASK_W-1] = cfg_mask[MASK_W-1];
  for (genvar k = MASK_W - 2; k >= 0; k--) begin : g_prefix
    assign eff_mask[k] = cfg_mask[k] & eff_mask[k+1];
  end

  assign fixed_hit = &addr_hi[HI_W-1 -: FIX_W];
  assign rom_hit   = fixed_hit & (&(addr_hi[MASK_W-1:0] | ~eff_mask));

  assign lo_sel  = ~mreq_n & ~addr_hi[HI_W-1];
  assign rom_sel = ~mreq_n & rom_hit;
  assign hi_sel  = ~mreq_n & addr_hi[HI_W-1] & ~rom_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_ram_cs_n <= 1'b1;
      hi_ram_cs_n <= 1'b1;
      rom_cs_n    <= 1'b1;
    end else begin
      lo_ram_cs_n <= ~lo_sel;
      hi_ram_cs_n <= ~hi_sel;
      rom_cs_n    <= ~rom_sel;
    end
  end

endmodule

// File: rtl/rom_window_decoder_chk.sv
module rom_window_decoder_chk #(
  parameter int HI_W  = 8,
  parameter int FIX_W = 3,
  localparam int MASK_W = HI_W - FIX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HI_W-1:0]   addr_hi,
  input logic              mreq_n,
  input logic [MASK_W-1:0] cfg_mask,
  input logic              lo_ram_cs_n,
  input logic              hi_ram_cs_n,
  input logic              rom_cs_n
);

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  AST_RESET_IDLE: assert property (@(posedge clk)
    (!rst_n || !armed) |=> (lo_ram_cs_n && hi_ram_cs_n && rom_cs_n) || rst_n); // R1
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~lo_ram_cs_n, ~hi_ram_cs_n, ~rom_cs_n}) <= 1); // R9
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mreq_n)) |-> (lo_ram_cs_n && hi_ram_cs_n && rom_cs_n)); // R4
  AST_LO_RAM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (lo_ram_cs_n == ($past(mreq_n) | $past(addr_hi[HI_W-1])))); // R3
  AST_ROM_IN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rom_cs_n) |-> ($past(&addr_hi[HI_W-1 -: FIX_W]) && !$past(mreq_n))); // R6
  AST_HI_RAM_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !hi_ram_cs_n) |-> ($past(addr_hi[HI_W-1]) && !$past(mreq_n))); // R8
  AST_UPPER_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(mreq_n) && $past(addr_hi[HI_W-1])) |-> (hi_ram_cs_n != rom_cs_n)); // R8

endmodule

bind rom_window_decoder rom_window_decoder_chk #(.HI_W(HI_W), .FIX_W(FIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .mreq_n(mreq_n), .cfg_mask(cfg_mask),
  .lo_ram_cs_n(lo_ram_cs_n), .hi_ram_cs_n(hi_ram_cs_n), .rom_cs_n(rom_cs_n)
);

// File: tb/tb_rom_window_decoder.sv
module tb_rom_window_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr_hi = 8'h00;
  logic       mreq_n = 1'b1;
  logic [4:0] cfg_mask = 5'b0;
  logic       lo_ram_cs_n, hi_ram_cs_n, rom_cs_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  rom_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .mreq_n(mreq_n), .cfg_mask(cfg_mask),
    .lo_ram_cs_n(lo_ram_cs_n), .hi_ram_cs_n(hi_ram_cs_n), .rom_cs_n(rom_cs_n)
  );

  function automatic int rom_base(input logic [4:0] m);
    int n = 0;
    for (int k = 4; k >= 0; k--)
      if (m[k] && n == 4 - k) n++;
    return 32'h10000 - (32'h2000 >> n);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (addr %h mreq_n %b mask %b)",
               req, act, exp, addr_hi, mreq_n, cfg_mask);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic rq_n, input logic [4:0] m, input string rom_tag);
    logic [2:0] e;
    int full;
    @(negedge clk);
    addr_hi = a; mreq_n = rq_n; cfg_mask = m;
    full = int'(a) * 256;
    e = 3'b111;
    if (!rq_n) begin
      if (!a[7]) e[2] = 1'b0;
      else if (full >= rom_base(m)) e[0] = 1'b0;
      else e[1] = 1'b0;
    end
    exp_q.push_back(e);
    tag_q.push_back(rq_n ? "R4" : rom_tag);
  endtask

  // R2: the entry queued at a falling edge is compared just after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t == "R4" ? "R4" : "R3", lo_ram_cs_n, e[2]);
        check(t == "R4" ? "R4" : "R8", hi_ram_cs_n, e[1]);
        check(t, rom_cs_n, e[0]);
        check("R9", logic'($countones({~lo_ram_cs_n, ~hi_ram_cs_n, ~rom_cs_n}) <= 1), 1'b1);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", lo_ram_cs_n, 1'b1);
    check("R1", hi_ram_cs_n, 1'b1);
    check("R1", rom_cs_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", lo_ram_cs_n & hi_ram_cs_n & rom_cs_n, 1'b1);

    drive(8'hE0, 1'b0, 5'b00000, "R5");
    drive(8'hDF, 1'b0, 5'b00000, "R5");
    drive(8'hFF, 1'b0, 5'b11111, "R10");
    drive(8'hFE, 1'b0, 5'b11111, "R10");
    drive(8'h80, 1'b0, 5'b11111, "R10");
    drive(8'hE0, 1'b0, 5'b01111, "R7");
    drive(8'hF0, 1'b0, 5'b10111, "R7");
    drive(8'hFF, 1'b1, 5'b00000, "R4");
    drive(8'h00, 1'b1, 5'b00000, "R4");

    for (int m = 0; m < 32; m++)
      for (int a = 0; a < 256; a++)
        for (int r = 0; r < 2; r++)
          drive(8'(a), 1'(r), 5'(m), "R6");

    @(negedge clk);
    mreq_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (40000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule